// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic stage of a 16-bit integer datapath. Each cycle it can take two operands, a 3-bit operation code and the current carry flag. It can add, add with carry, subtract, subtract with borrow, compare, negate, increment or decrement. One clock later it presents the 16-bit result and a six-bit flag vector with overflow, sign, zero, auxiliary carry, parity and carry. It also returns a mask of the flags the operation defines and a write enable that says whether the result belongs in the destination.

The surrounding pipeline fetches the operands, decodes the instruction and commits the outputs. The unit holds no architectural state besides its output register. The carry flag is passed in and, where the operation keeps it, passed back unchanged.

Top module: `alu16_flagunit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_done`, `out_write`, `out_result`, `out_flags` and `out_flag_mask` all become zero.
- R2: `out_done` is high exactly in the cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_result`, `out_flags` and `out_flag_mask` keep their values and `out_write` is low.
- R3: Operation code 0 (add) gives `opa + opb`. Code 1 (add with carry) gives `opa + opb + carry_in`. In both, carry (flag bit 0) is the carry out of bit 15 of the full sum.
- R4: Code 2 (subtract) gives `opa - opb`. Code 3 (subtract with borrow) gives `opa - (opb + carry_in)`. In both, carry is set when an unsigned borrow occurs.
- R5: Code 4 (compare) sets all six flags as subtract does. `out_result` shows the difference, but `out_write` stays low. Every other operation raises `out_write` with `out_done`.
- R6: Code 5 (negate) gives `0 - opa` and ignores `opb`. Carry is set exactly when `opa` is nonzero. Overflow is set only for `opa` = 0x8000.
- R7: Code 6 (increment) gives `opa + 1` and code 7 (decrement) gives `opa - 1`, both ignoring `opb`. Their carry bit equals `carry_in` and their `out_flag_mask` is 6'b111110. Every other operation reports a mask of 6'b111111.
- R8: Zero (bit 3) is set when the result is 0. Sign (bit 4) copies result bit 15. Parity (bit 1) is set when the low 8 result bits hold an even number of ones.
- R9: Auxiliary carry (bit 2) is bit 4 of (first operand XOR second operand XOR result). The second operand is `opb` for the two-operand codes, 1 for increment and decrement, and `opa` for negate, whose first operand is 0.
- R10: Overflow (bit 5) for additions is set when both operands share a sign that the result does not. For subtractions, compare, negate and decrement it is set when the operand signs differ and the result sign differs from the first operand's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| op | input | 3 | Operation code (0 add … 7 decrement) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Carry flag held before the operation |
| out_done | output | 1 | Result valid pulse, one cycle after the request |
| out_result | output | 16 | Arithmetic result |
| out_write | output | 1 | Result is to be stored |
| out_flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| out_flag_mask | output | 6 | Flags defined by this operation, same bit order |

## Verification
On every cycle the assertions check four things against the inputs of the previous cycle. They check the one-cycle done pulse and that outputs hold when no request arrives. They check that compare never writes and that increment and decrement pass the carry through. They also check that the zero, sign and parity flags agree with the registered result, and that negate flags overflow only for 0x8000. The arithmetic values and the auxiliary-carry and overflow flags for each operation can only be shown by the bench's vectors. These vectors cover wraparound at 0xFFFF and 0x7FFF, borrow with an incoming carry, and operands `opb` that the single-operand codes must ignore.

// File: rtl/alu16_pkg.sv
// Package: operation codes and flag bit positions shared by the ALU modules.
// Assumes the flag vector order {O,S,Z,A,P,C} from bit 5 down to bit 0.
package alu16_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_NEG = 3'd5,
        OP_INC = 3'd6,
        OP_DEC = 3'd7
    } alu_op_e;

    localparam int NFLAGS = 6;
    localparam int FLG_C  = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_A  = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_S  = 4;
    localparam int FLG_O  = 5;
endpackage

// File: rtl/alu16_opsel.sv
// Operand selector: maps an operation code onto one shared adder.
// Produces the first and second logical operands, whether the adder
// subtracts, the carry-in, whether carry is preserved and whether the
// result is stored. Purely combinational.
module alu16_opsel
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry_in,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         do_sub,
    output logic         cin,
    output logic         keep_carry,
    output logic         store
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Decode operation into adder controls.
    always_comb begin
        x          = opa;
        y          = opb;
        do_sub     = 1'b0;
        cin        = 1'b0;
        keep_carry = 1'b0;
        store      = 1'b1;
        case (alu_op_e'(op))
            OP_ADD: ;
            OP_ADC: cin = carry_in;
            OP_SUB: begin do_sub = 1'b1; cin = 1'b1; end
            OP_SBB: begin do_sub = 1'b1; cin = ~carry_in; end
            OP_CMP: begin do_sub = 1'b1; cin = 1'b1; store = 1'b0; end
            OP_NEG: begin x = '0; y = opa; do_sub = 1'b1; cin = 1'b1; end
            OP_INC: begin y = ONE; keep_carry = 1'b1; end
            OP_DEC: begin y = ONE; do_sub = 1'b1; cin = 1'b1; keep_carry = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_adder.sv
// Shared adder: x + (y or ~y) + cin, with the carry out of the top bit.
// Assumes the subtract carry-in is already inverted by the selector.
module alu16_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         do_sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] y_eff;
    logic [W:0]   full;

    // Single carry-propagate addition over W+1 bits.
    always_comb begin
        y_eff = do_sub ? ~y : y;
        full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
        sum   = full[W-1:0];
        cout  = full[W];
    end
endmodule

// File: rtl/alu16_flaggen.sv
// Flag generator: derives the six status flags from the logical operands,
// the result and the adder carry. Assumes y is the un-inverted second operand.
module alu16_flaggen
    import alu16_pkg::*;
#(
    parameter int W     = 16,
    parameter int PAR_W = 8
) (
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    input  logic [W-1:0]      sum,
    input  logic              cout,
    input  logic              do_sub,
    input  logic              keep_carry,
    input  logic              carry_in,
    output logic [NFLAGS-1:0] flags,
    output logic [NFLAGS-1:0] mask
);
    localparam int MSB = W - 1;
    localparam int AUX_BIT = 4;

    logic [W-1:0] half_mix;
    logic         sign_diff;

    // Compute each flag; carry is a borrow for subtraction.
    always_comb begin
        half_mix  = x ^ y ^ sum;
        sign_diff = x[MSB] ^ y[MSB];
        flags        = '0;
        flags[FLG_Z] = (sum == '0);
        flags[FLG_S] = sum[MSB];
        flags[FLG_P] = ~^sum[PAR_W-1:0];
        flags[FLG_A] = half_mix[AUX_BIT];
        flags[FLG_O] = (do_sub ? sign_diff : ~sign_diff) & (sum[MSB] ^ x[MSB]);
        flags[FLG_C] = keep_carry ? carry_in : (cout ^ do_sub);
        mask         = '1;
        mask[FLG_C]  = ~keep_carry;
    end
endmodule

// File: rtl/alu16_flagunit.sv
// Top: registered 16-bit arithmetic unit with status flags.
// Inputs are sampled when in_valid is high; results, flags, flag mask and
// write enable appear one clock later with out_done. Outputs hold otherwise.
module alu16_flagunit
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              carry_in,
    output logic              out_done,
    output logic [W-1:0]      out_result,
    output logic              out_write,
    output logic [NFLAGS-1:0] out_flags,
    output logic [NFLAGS-1:0] out_flag_mask
);
    logic [W-1:0]      x, y, sum;
    logic              do_sub, cin, keep_carry, store, cout;
    logic [NFLAGS-1:0] flags_c, mask_c;

    alu16_opsel #(.W(W)) u_sel (
        .op(op), .opa(opa), .opb(opb), .carry_in(carry_in),
        .x(x), .y(y), .do_sub(do_sub), .cin(cin),
        .keep_carry(keep_carry), .store(store)
    );

    alu16_adder #(.W(W)) u_add (
        .x(x), .y(y), .do_sub(do_sub), .cin(cin), .sum(sum), .cout(cout)
    );

    alu16_flaggen #(.W(W), .PAR_W(8)) u_flg (
        .x(x), .y(y), .sum(sum), .cout(cout), .do_sub(do_sub),
        .keep_carry(keep_carry), .carry_in(carry_in),
        .flags(flags_c), .mask(mask_c)
    );

    // Output register: capture on request, hold otherwise, done pulses once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done      <= 1'b0;
            out_write     <= 1'b0;
            out_result    <= '0;
            out_flags     <= '0;
            out_flag_mask <= '0;
        end else begin
            out_done  <= in_valid;
            out_write <= in_valid & store;
            if (in_valid) begin
                out_result    <= sum;
                out_flags     <= flags_c;
                out_flag_mask <= mask_c;
            end
        end
    end

    assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && !out_write && $stable(out_result) && $stable(out_flags)));
    assert_compare_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> !out_write);
    assert_keep_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd6 || op == 3'd7)) |=>
            (out_flags[FLG_C] == $past(carry_in) && !out_flag_mask[FLG_C]));
    assert_neg_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5) |=>
            (out_flags[FLG_O] == ($past(opa) == {1'b1, {(W-1){1'b0}}})));
    assert_result_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_flags[FLG_Z] == (out_result == '0) &&
                      out_flags[FLG_S] == out_result[W-1] &&
                      out_flags[FLG_P] == ~^out_result[7:0]));
endmodule

// File: tb/tb_alu16_flagunit.sv
module tb_alu16_flagunit;
    localparam int N = 19;
    // {op[3], opa[16], opb[16], cin[1], result[16], flags{O,S,Z,A,P,C}[6]}
    localparam logic [57:0] VEC [N] = '{
        {3'd0, 16'h0001, 16'h0002, 1'b0, 16'h0003, 6'b000010},
        {3'd0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 6'b110110},
        {3'd0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 6'b001111},
        {3'd1, 16'h1234, 16'h0001, 1'b1, 16'h1236, 6'b000010},
        {3'd1, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 6'b001111},
        {3'd2, 16'h0005, 16'h0003, 1'b1, 16'h0002, 6'b000000},
        {3'd2, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 6'b010101},
        {3'd2, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 6'b100110},
        {3'd3, 16'h0010, 16'h0005, 1'b1, 16'h000A, 6'b000110},
        {3'd3, 16'h0000, 16'h0000, 1'b1, 16'hFFFF, 6'b010111},
        {3'd4, 16'h1234, 16'h1234, 1'b0, 16'h0000, 6'b001010},
        {3'd4, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 6'b010101},
        {3'd5, 16'h0000, 16'hAAAA, 1'b1, 16'h0000, 6'b001010},
        {3'd5, 16'h0001, 16'h5555, 1'b0, 16'hFFFF, 6'b010111},
        {3'd5, 16'h8000, 16'h1234, 1'b0, 16'h8000, 6'b110011},
        {3'd6, 16'h00FF, 16'hAAAA, 1'b1, 16'h0100, 6'b000111},
        {3'd6, 16'h7FFF, 16'h5555, 1'b0, 16'h8000, 6'b110110},
        {3'd7, 16'h0000, 16'h0F0F, 1'b0, 16'hFFFF, 6'b010110},
        {3'd7, 16'h8000, 16'hFFFF, 1'b1, 16'h7FFF, 6'b100111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] opa = '0, opb = '0;
    logic        carry_in = 1'b0;
    logic        out_done, out_write;
    logic [15:0] out_result;
    logic [5:0]  out_flags, out_flag_mask;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alu16_flagunit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
        .opb(opb), .carry_in(carry_in), .out_done(out_done),
        .out_result(out_result), .out_write(out_write), .out_flags(out_flags),
        .out_flag_mask(out_flag_mask)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge; outputs are read one cycle later.
    task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        in_valid = 1'b1; op = o; opa = a; opb = b; carry_in = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {15'd0, out_done}, 16'd0);
        check("R1 write", {15'd0, out_write}, 16'd0);
        check("R1 result", out_result, 16'd0);
        check("R1 flags", {10'd0, out_flags}, 16'd0);
        check("R1 mask", {10'd0, out_flag_mask}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            logic [2:0] vop;
            vop = VEC[i][57:55];
            issue(vop, VEC[i][54:39], VEC[i][38:23], VEC[i][22]);
            // R3 R4 R5 R6 R7 result; R8 R9 R10 flags
            check($sformatf("R3/R4/R6/R7 result vec %0d", i), out_result, VEC[i][21:6]);
            check($sformatf("R8/R9/R10 flags vec %0d", i), {10'd0, out_flags}, {10'd0, VEC[i][5:0]});
            check($sformatf("R5 write vec %0d", i), {15'd0, out_write}, {15'd0, vop != 3'd4});
            check($sformatf("R7 mask vec %0d", i), {10'd0, out_flag_mask},
                  (vop == 3'd6 || vop == 3'd7) ? 16'h003E : 16'h003F);
            check($sformatf("R2 done vec %0d", i), {15'd0, out_done}, 16'd1);
        end

        // R2: idle cycle with changed inputs leaves outputs alone
        @(negedge clk);
        opa = 16'h4444; opb = 16'h2222; op = 3'd0;
        @(negedge clk);
        check("R2 idle done", {15'd0, out_done}, 16'd0);
        check("R2 idle write", {15'd0, out_write}, 16'd0);
        check("R2 idle result held", out_result, 16'h7FFF);
        check("R2 idle flags held", {10'd0, out_flags}, 16'h0027);

        // R1: reset after activity clears the outputs
        issue(3'd0, 16'h0100, 16'h0200, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset result", out_result, 16'd0);
        check("R1 reset mask", {10'd0, out_flag_mask}, 16'd0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule